// File: doc/BRIEF.md
# Loadable Ternary-Match State-Table Controller

This block is the control unit of a small processor, built as a programmable logic array instead of fixed gates. It holds a table of rows. Each row stores a three-valued condition over the registered state code and the live controller inputs, a next-state code and a vector of control outputs. Every cycle, all rows are compared at once against the current state and inputs. The control outputs and the next state are the bitwise OR of the stored fields of every row that matches.

The table is filled through a row-write port, so a control sequence can be changed without changing the hardware. A properly written table is orthogonal and complete, which means exactly one row matches any combination of state and inputs. Two flags check this at run time: one reports that no row matched and one reports that several rows matched. The state register moves on the falling clock edge only. The outputs follow the inputs combinationally, so the block behaves as a Mealy machine.

Top module: `pla_ctrl`

## Requirements
- R1: The condition vector is {state[4:0], in_sig[13:0]}, with state in bits 18..14. For each bit of a row, care=1 with value=1 requires the bit to be 1, care=1 with value=0 requires it to be 0, and care=0 ignores the bit.
- R2: A row matches only when its valid bit is set and every bit it cares about agrees with the condition vector.
- R3: `ctrl_out` is the bitwise OR of the stored output fields of all matching rows.
- R4: `next_state` is the bitwise OR of the stored next-state fields of all matching rows. `state` loads `next_state` on every falling clock edge and changes at no other time.
- R5: A valid row with care=0, a zero output field and a zero next-state field matches everything and leaves `ctrl_out` and `next_state` unchanged.
- R6: When no valid row matches, `no_match` is 1 and `ctrl_out` and `next_state` are all zeros.
- R7: `multi_match` is 1 when two or more valid rows match in the same cycle. `no_match` and `multi_match` are never 1 together.
- R8: While `rst` is high at a falling edge, `state` loads START_CODE (default 0) and every row becomes invalid.
- R9: On a falling edge with `wr_en` high, row `wr_addr` takes the care, value, next-state and output fields and the valid bit `wr_valid`. A write to an address of ROWS or above has no effect.
- R10: `ctrl_out`, `next_state` and both flags follow `in_sig` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| in_sig | input | 14 | Live controller input signals |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 7 | Row to write |
| wr_valid | input | 1 | Valid bit stored with the row |
| wr_care | input | 19 | Care mask of the condition |
| wr_value | input | 19 | Required values of the cared bits |
| wr_next | input | 5 | Next-state field of the row |
| wr_out | input | 27 | Output field of the row |
| state | output | 5 | Registered state code |
| next_state | output | 5 | OR of the next-state fields of matching rows |
| ctrl_out | output | 27 | OR of the output fields of matching rows |
| no_match | output | 1 | No valid row matches |
| multi_match | output | 1 | Two or more valid rows match |

## Verification
Two functions can fall in the same cycle. A row can be written on the same falling edge on which the state advances, and several rows can match together. To provoke the first case, the bench writes rows while the machine is running. It then predicts that the state transition on that edge uses the table as it was before the write. To provoke the second case, the bench adds a catch-all row that overlaps a normal row. It expects the merged output and next-state values and a raised multi-match flag in the same cycle, and then checks that a state reached only through the merged code is decoded on the next cycle.

// File: rtl/pla_ctrl.sv
module pla_ctrl #(
  parameter int ST_W = 5,
  parameter int IN_W = 14,
  parameter int OUT_W = 27,
  parameter int ROWS = 98,
  parameter int AW = $clog2(ROWS),
  parameter logic [ST_W-1:0] START_CODE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    in_sig,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic               wr_valid,
  input  logic [ST_W+IN_W-1:0] wr_care,
  input  logic [ST_W+IN_W-1:0] wr_value,
  input  logic [ST_W-1:0]    wr_next,
  input  logic [OUT_W-1:0]   wr_out,
  output logic [ST_W-1:0]    state,
  output logic [ST_W-1:0]    next_state,
  output logic [OUT_W-1:0]   ctrl_out,
  output logic               no_match,
  output logic               multi_match
);
  localparam int CW = ST_W + IN_W;
  localparam logic [AW:0] ROWS_L = ROWS[AW:0];

  logic [ROWS-1:0] row_ok;
  logic [CW-1:0]   care_m [ROWS];
  logic [CW-1:0]   val_m  [ROWS];
  logic [ST_W-1:0] nxt_m  [ROWS];
  logic [OUT_W-1:0] out_m [ROWS];
  logic [ROWS-1:0] hit;
  logic [CW-1:0]   cond;
  logic            wr_hit;

  assign cond   = {state, in_sig};
  assign wr_hit = wr_en && ({1'b0, wr_addr} < ROWS_L);

  always_ff @(negedge clk) begin
    if (rst) row_ok <= '0;
    else if (wr_hit) row_ok[wr_addr] <= wr_valid;
  end

  always_ff @(negedge clk) begin
    if (!rst && wr_hit) begin
      care_m[wr_addr] <= wr_care;
      val_m[wr_addr]  <= wr_value;
      nxt_m[wr_addr]  <= wr_next;
      out_m[wr_addr]  <= wr_out;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign hit[g] = row_ok[g] && (((cond ^ val_m[g]) & care_m[g]) == '0);
  end

  logic any_hit, two_hit;
  always_comb begin
    ctrl_out   = '0;
    next_state = '0;
    any_hit    = 1'b0;
    two_hit    = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (hit[r]) begin
        two_hit    = two_hit | any_hit;
        any_hit    = 1'b1;
        ctrl_out   = ctrl_out | out_m[r];
        next_state = next_state | nxt_m[r];
      end
    end
  end

  assign no_match    = !any_hit;
  assign multi_match = two_hit;

  always_ff @(negedge clk) begin
    if (rst) state <= START_CODE;
    else     state <= next_state;
  end
endmodule

// File: rtl/pla_ctrl_chk.sv
module pla_ctrl_chk #(
  parameter int ST_W = 5,
  parameter int OUT_W = 27,
  parameter logic [ST_W-1:0] START_CODE = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [ST_W-1:0]  state,
  input logic [ST_W-1:0]  next_state,
  input logic [OUT_W-1:0] ctrl_out,
  input logic             no_match,
  input logic             multi_match
);
  a_r4_state_load: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> state == $past(next_state));

  a_r6_empty_zero: assert property (@(negedge clk) disable iff (rst)
    no_match |-> (ctrl_out == '0 && next_state == '0));

  a_r7_flags_apart: assert property (@(negedge clk) disable iff (rst)
    !(no_match && multi_match));

  a_r8_reset_start: assert property (@(negedge clk)
    rst |=> state == START_CODE);
endmodule

bind pla_ctrl pla_ctrl_chk #(.ST_W(ST_W), .OUT_W(OUT_W), .START_CODE(START_CODE)) i_chk (
  .clk(clk), .rst(rst), .state(state), .next_state(next_state),
  .ctrl_out(ctrl_out), .no_match(no_match), .multi_match(multi_match));

// File: tb/test_pla_ctrl.sv
`timescale 1ns/1ps
module test_pla_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] in_sig = '0;
  logic wr_en = 1'b0, wr_valid = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [18:0] wr_care = '0, wr_value = '0;
  logic [4:0] wr_next = '0;
  logic [26:0] wr_out = '0;
  logic [4:0] state, next_state;
  logic [26:0] ctrl_out;
  logic no_match, multi_match;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pla_ctrl i_pla_ctrl (.clk(clk), .rst(rst), .in_sig(in_sig), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_valid(wr_valid), .wr_care(wr_care), .wr_value(wr_value),
    .wr_next(wr_next), .wr_out(wr_out), .state(state), .next_state(next_state),
    .ctrl_out(ctrl_out), .no_match(no_match), .multi_match(multi_match));

  localparam logic [18:0] ST_ALL = 19'h7C000;

  // {in_sig, state seen, expected ctrl_out, expected next_state}
  localparam logic [50:0] VEC [9] = '{
    {14'h0000, 5'd0, 27'h0000001, 5'd1},
    {14'h0000, 5'd1, 27'h0000002, 5'd1},
    {14'h0001, 5'd1, 27'h000000C, 5'd2},
    {14'h0002, 5'd2, 27'h0000010, 5'd3},
    {14'h0000, 5'd3, 27'h0000040, 5'd0},
    {14'h0000, 5'd0, 27'h0000001, 5'd1},
    {14'h0001, 5'd1, 27'h000000C, 5'd2},
    {14'h0000, 5'd2, 27'h0000020, 5'd0},
    {14'h3FFF, 5'd0, 27'h0000001, 5'd1}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic [13:0] v);
    @(posedge clk); #1 in_sig = v; #1;
  endtask

  task automatic wrow(input logic [6:0] a, input logic vld, input logic [18:0] c,
                      input logic [18:0] v, input logic [4:0] n, input logic [26:0] o);
    @(posedge clk); #1;
    wr_addr = a; wr_valid = vld; wr_care = c; wr_value = v; wr_next = n; wr_out = o;
    wr_en = 1'b1;
    @(negedge clk); #1 wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    step(14'h0);
    check("R8 state after reset", state, 0);
    check("R8 rows invalid no_match", no_match, 1);
    check("R6 outputs zero", ctrl_out, 0);

    wrow(7'd1, 1, ST_ALL | 19'h1, {5'd1, 14'h0}, 5'd1, 27'h2);
    wrow(7'd2, 1, ST_ALL | 19'h1, {5'd1, 14'h1}, 5'd2, 27'hC);
    wrow(7'd3, 1, ST_ALL | 19'h2, {5'd2, 14'h2}, 5'd3, 27'h10);
    wrow(7'd4, 1, ST_ALL | 19'h2, {5'd2, 14'h0}, 5'd0, 27'h20);
    wrow(7'd5, 1, ST_ALL, {5'd3, 14'h0}, 5'd0, 27'h40);
    wrow(7'd0, 1, ST_ALL, {5'd0, 14'h0}, 5'd1, 27'h1);

    for (int i = 0; i < 9; i++) begin
      step(VEC[i][50:37]);
      check("R4 state sequence", state, VEC[i][36:32]);
      check("R1 R2 R3 ctrl_out", ctrl_out, VEC[i][31:5]);
      check("R4 next_state", next_state, VEC[i][4:0]);
    end

    step(14'h0);
    check("R10 waiting output", ctrl_out, 27'h2);
    #1 in_sig = 14'h1; #1;
    check("R10 same-cycle output", ctrl_out, 27'hC);
    check("R10 same-cycle next", next_state, 2);
    step(14'h0);
    check("R4 advanced on edge", state, 2);

    wrow(7'd6, 1, 19'h0, 19'h0, 5'h10, 27'h4000000);
    step(14'h0);
    check("R4 write edge used old table", state, 1);
    check("R7 merged output", ctrl_out, 27'h4000002);
    check("R7 merged next", next_state, 5'h11);
    check("R7 multi_match", multi_match, 1);
    step(14'h0);
    check("R4 merged state", state, 5'h11);
    check("R7 single match", multi_match, 0);
    check("R3 catch-all output", ctrl_out, 27'h4000000);

    wrow(7'd6, 1, 19'h0, 19'h0, 5'h0, 27'h0);
    step(14'h0);
    check("R5 blank row state", state, 5'h10);
    check("R5 blank row output", ctrl_out, 0);
    check("R5 blank row matches", no_match, 0);

    wrow(7'd100, 1, 19'h0, 19'h0, 5'h1F, 27'h4000000);
    step(14'h0);
    check("R9 state", state, 1);
    check("R9 out-of-range ignored", ctrl_out, 27'h2);
    check("R9 next unchanged", next_state, 1);

    wrow(7'd6, 0, 19'h0, 19'h0, 5'h0, 27'h0);
    wrow(7'd1, 0, 19'h0, 19'h0, 5'h0, 27'h0);
    step(14'h0);
    check("R9 invalidate no_match", no_match, 1);
    check("R6 zero output", ctrl_out, 0);
    check("R6 zero next", next_state, 0);
    step(14'h0);
    check("R6 state to zero", state, 0);

    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    step(14'h0);
    check("R8 start code", state, 0);
    check("R8 table cleared", no_match, 1);
    check("R8 output cleared", ctrl_out, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule